// File: doc/BRIEF.md
# I2C Byte Buffer and Flag Sequencer

This block is the register-side buffering stage of a multi-master I2C controller. It sits between a CPU register port and a byte-level shift engine. The engine is reduced to strobes: a byte-complete pulse with a flag marking address bytes, the received byte, the sampled acknowledge bit, an address-match flag, arbitration loss, and start and stop detection. The block decides when the byte written by the CPU moves into the output shifter. It captures incoming bytes into a visible receive register backed by one holding stage. It maintains the transmit-empty, receive-full, receive-interrupt, overrun and bus-busy flags.

In master mode, outgoing data advances only on an acknowledge. A missing acknowledge leaves the byte parked and raises a request to end or restart the transfer. In slave mode, written data waits for the next matching call, and the receive register shows the calling address after a match. Losing arbitration drops the bus drive request in the same cycle. Clearing the enable is the recovery path when a stop never arrives: it clears every register and flag, including bus-busy.

Top module: `i2c_byte_buffer`

## Requirements
- R1: In master mode with `xmitDir`=1, a `byteDone` with `ackBit`=0, for an address byte or a data byte, while a byte is pending (`txEmpty`=0) gives `shLoad`=1 for one cycle on the next cycle, with `shData` equal to the pending byte and `txEmpty` back at 1. With no byte pending, an acknowledge loads nothing.
- R2: In master mode, a `byteDone` with `ackBit`=1 loads nothing. `txEmpty` stays 0, and `stopReq` pulses for one cycle on the next cycle.
- R3: In slave mode, a written byte waits, with `txEmpty`=0, until an address byte arrives with `addrMatch`=1 and `xmitDir`=1. On the next cycle it appears on `shData` with `shLoad`=1. An unmatched address byte loads nothing.
- R4: In slave mode, an address byte with `addrMatch`=1 is captured into `rxRdData`. An address byte with `addrMatch`=0 is ignored, and `rxFull` stays 0. A data byte with `xmitDir`=0 is captured.
- R5: In master mode, address bytes are never captured. Data bytes with `xmitDir`=0 are captured into `rxRdData`.
- R6: A `rxRdEn` pulse while `rxFull`=1 clears `rxFull` when nothing is held. If a byte is held, the held byte moves into `rxRdData` and `rxFull` stays 1.
- R7: Each load of `rxRdData` sets `rxIrq`. Moving a byte into the holding stage does not set it. A `rxFlagClr` pulse clears `rxIrq`, but a load in the same cycle wins.
- R8: A captured byte that arrives while both `rxRdData` and the holding stage are full sets `rxOverrun` and is discarded. `rxFlagClr` clears `rxOverrun`.
- R9: `busDrvReq` rises the cycle after a `startDet` in master mode. It is 0 in the same cycle that `arbLost` is 1, and it stays 0 after that until the next start.
- R10: `busBusy` is set by `startDet` and cleared only by `stopDet` or by `enable`=0. When `enable` is set again, operation resumes.
- R11: With `enable`=0, every output is 0, including `txEmpty`, and CPU writes are ignored. With `enable`=1 and nothing written, `txEmpty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; 0 clears all state |
| masterMode | input | 1 | 1 = master, 0 = slave |
| xmitDir | input | 1 | 1 = this side sends the data bytes |
| txWrEn | input | 1 | CPU write strobe for the transmit register |
| txWrData | input | DATA_W | CPU write data |
| rxRdEn | input | 1 | CPU read strobe for the receive register |
| rxFlagClr | input | 1 | Write-1 clear of the interrupt and overrun flags |
| byteDone | input | 1 | Engine finished one byte |
| byteIsAddr | input | 1 | The finished byte was an address byte |
| byteRx | input | DATA_W | Byte received by the engine |
| ackBit | input | 1 | Acknowledge bit, 0 = ACK |
| addrMatch | input | 1 | Own slave address matched |
| arbLost | input | 1 | Arbitration lost |
| startDet | input | 1 | Start condition seen |
| stopDet | input | 1 | Stop condition seen |
| rxRdData | output | DATA_W | Visible receive register |
| txEmpty | output | 1 | Transmit register empty |
| rxFull | output | 1 | Receive register holds unread data |
| rxIrq | output | 1 | Receive interrupt flag |
| rxOverrun | output | 1 | Receive byte discarded |
| busBusy | output | 1 | Bus busy |
| busDrvReq | output | 1 | Request to drive SDA/SCL |
| shLoad | output | 1 | Shifter load pulse |
| shData | output | DATA_W | Byte handed to the shifter |
| stopReq | output | 1 | Request for a stop or repeated start |

## Verification
The hardest case to reach is a byte arriving when both the visible register and the holding stage are full. The bench gets there by sending three data bytes with no read in between. It then reads twice to show that the second byte comes forward and the third was dropped. The arbitration-loss release is checked one time step after the strobe is driven, inside the same clock cycle. The recovery from a missing stop is reached by starting a transfer, losing arbitration, and then toggling the enable.

// File: rtl/i2cbuf_pkg.sv
package i2cbuf_pkg;
  typedef struct packed {
    logic clrAll;
    logic txWr;
    logic shLoad;
    logic mainFromNew;
    logic mainFromHold;
    logic holdFromNew;
  } dpStrb_t;
endpackage

// File: rtl/i2cbuf_ctrl.sv
module i2cbuf_ctrl
  import i2cbuf_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    masterMode,
  input  logic    xmitDir,
  input  logic    txWrEn,
  input  logic    rxRdEn,
  input  logic    rxFlagClr,
  input  logic    byteDone,
  input  logic    byteIsAddr,
  input  logic    ackBit,
  input  logic    addrMatch,
  input  logic    arbLost,
  input  logic    startDet,
  input  logic    stopDet,
  output dpStrb_t strb,
  output logic    txFull,
  output logic    rxFull,
  output logic    rxOverrun,
  output logic    rxIrq,
  output logic    busBusy,
  output logic    busOwn,
  output logic    stopReq
);
  logic holdFull;
  logic rxCapture, readOk, overrunHit, mainLoad;
  logic ackOk, mLoad, sLoad;

  always_comb begin
    // which finished bytes enter the receive path
    rxCapture = enable && byteDone && !arbLost &&
                ((!masterMode && byteIsAddr && addrMatch) || (!byteIsAddr && !xmitDir));
    ackOk = byteDone && !ackBit && !arbLost;
    mLoad = masterMode && xmitDir && ackOk;
    sLoad = !masterMode && xmitDir && byteDone &&
            ((byteIsAddr && addrMatch) || (!byteIsAddr && !ackBit));
    readOk = enable && rxRdEn && rxFull;

    strb.clrAll       = !enable;
    strb.txWr         = enable && txWrEn;
    strb.shLoad       = enable && txFull && (mLoad || sLoad);
    strb.mainFromHold = readOk && holdFull;
    strb.mainFromNew  = rxCapture && (!rxFull || (readOk && !holdFull));
    strb.holdFromNew  = rxCapture && ((readOk && holdFull) ||
                                      (!readOk && rxFull && !holdFull));
    overrunHit = rxCapture && !readOk && rxFull && holdFull;
    mainLoad   = strb.mainFromNew || strb.mainFromHold;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFull    <= 1'b0;
      rxFull    <= 1'b0;
      holdFull  <= 1'b0;
      rxOverrun <= 1'b0;
      rxIrq     <= 1'b0;
      busBusy   <= 1'b0;
      busOwn    <= 1'b0;
      stopReq   <= 1'b0;
    end else if (!enable) begin
      txFull    <= 1'b0;
      rxFull    <= 1'b0;
      holdFull  <= 1'b0;
      rxOverrun <= 1'b0;
      rxIrq     <= 1'b0;
      busBusy   <= 1'b0;
      busOwn    <= 1'b0;
      stopReq   <= 1'b0;
    end else begin
      if (strb.txWr) txFull <= 1'b1;
      else if (strb.shLoad) txFull <= 1'b0;

      if (mainLoad) rxFull <= 1'b1;
      else if (readOk) rxFull <= 1'b0;

      if (strb.holdFromNew) holdFull <= 1'b1;
      else if (strb.mainFromHold) holdFull <= 1'b0;

      if (overrunHit) rxOverrun <= 1'b1;
      else if (rxFlagClr) rxOverrun <= 1'b0;

      if (mainLoad) rxIrq <= 1'b1;
      else if (rxFlagClr) rxIrq <= 1'b0;

      if (startDet) busBusy <= 1'b1;
      else if (stopDet) busBusy <= 1'b0;

      if (arbLost || stopDet) busOwn <= 1'b0;
      else if (masterMode && startDet) busOwn <= 1'b1;

      stopReq <= masterMode && byteDone && ackBit && !arbLost;
    end
  end
endmodule

// File: rtl/i2cbuf_dpath.sv
module i2cbuf_dpath
  import i2cbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrb_t           strb,
  input  logic [DATA_W-1:0] txWrData,
  input  logic [DATA_W-1:0] byteRx,
  output logic [DATA_W-1:0] rxMain,
  output logic [DATA_W-1:0] shData,
  output logic              shLoad
);
  logic [DATA_W-1:0] txData;
  logic [DATA_W-1:0] rxHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData <= '0;
      rxHold <= '0;
      rxMain <= '0;
      shData <= '0;
      shLoad <= 1'b0;
    end else if (strb.clrAll) begin
      txData <= '0;
      rxHold <= '0;
      rxMain <= '0;
      shData <= '0;
      shLoad <= 1'b0;
    end else begin
      shLoad <= strb.shLoad;
      if (strb.shLoad) shData <= txData;
      if (strb.txWr) txData <= txWrData;
      if (strb.mainFromHold) rxMain <= rxHold;
      else if (strb.mainFromNew) rxMain <= byteRx;
      if (strb.holdFromNew) rxHold <= byteRx;
    end
  end
endmodule

// File: rtl/i2c_byte_buffer.sv
module i2c_byte_buffer
  import i2cbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              masterMode,
  input  logic              xmitDir,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              rxRdEn,
  input  logic              rxFlagClr,
  input  logic              byteDone,
  input  logic              byteIsAddr,
  input  logic [DATA_W-1:0] byteRx,
  input  logic              ackBit,
  input  logic              addrMatch,
  input  logic              arbLost,
  input  logic              startDet,
  input  logic              stopDet,
  output logic [DATA_W-1:0] rxRdData,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              rxIrq,
  output logic              rxOverrun,
  output logic              busBusy,
  output logic              busDrvReq,
  output logic              shLoad,
  output logic [DATA_W-1:0] shData,
  output logic              stopReq
);
  dpStrb_t strb;
  logic txFull, busOwn;

  i2cbuf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .masterMode(masterMode),
    .xmitDir(xmitDir), .txWrEn(txWrEn), .rxRdEn(rxRdEn), .rxFlagClr(rxFlagClr),
    .byteDone(byteDone), .byteIsAddr(byteIsAddr), .ackBit(ackBit),
    .addrMatch(addrMatch), .arbLost(arbLost), .startDet(startDet),
    .stopDet(stopDet), .strb(strb), .txFull(txFull), .rxFull(rxFull),
    .rxOverrun(rxOverrun), .rxIrq(rxIrq), .busBusy(busBusy),
    .busOwn(busOwn), .stopReq(stopReq)
  );

  i2cbuf_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .txWrData(txWrData),
    .byteRx(byteRx), .rxMain(rxRdData), .shData(shData), .shLoad(shLoad)
  );

  // empty only reads as 1 while the block is switched on
  assign txEmpty   = enable && !txFull;
  // drive request drops in the very cycle arbitration is lost
  assign busDrvReq = enable && busOwn && !arbLost;
endmodule

// File: rtl/i2cbuf_chk.sv
module i2cbuf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              masterMode,
  input logic              byteDone,
  input logic              ackBit,
  input logic              arbLost,
  input logic              stopDet,
  input logic              rxRdEn,
  input logic [DATA_W-1:0] rxRdData,
  input logic              txEmpty,
  input logic              rxFull,
  input logic              rxIrq,
  input logic              rxOverrun,
  input logic              busBusy,
  input logic              busDrvReq,
  input logic              shLoad,
  input logic              stopReq
);
  // R1
  a_r1_load_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    shLoad |-> $past(enable && !txEmpty));

  // R2
  a_r2_nack_holds: assert property (@(posedge clk) disable iff (!rstN)
    (enable && masterMode && byteDone && ackBit && !arbLost && !txEmpty && !rxRdEn)
    |=> (!shLoad && !txEmpty && (stopReq || !enable)));

  // R7
  a_r7_irq_on_load: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !$stable(rxRdData)) |-> rxIrq);

  // R8
  a_r8_overrun_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrun) |-> ($past(rxFull) && $past(byteDone)));

  // R9
  a_r9_arb_release: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |-> !busDrvReq);

  // R10
  a_r10_busy_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busBusy) |-> ($past(stopDet) || !$past(enable)));

  // R11
  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!busBusy && !rxFull && !rxIrq && !shLoad));
endmodule

bind i2c_byte_buffer i2cbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .masterMode(masterMode),
  .byteDone(byteDone), .ackBit(ackBit), .arbLost(arbLost), .stopDet(stopDet),
  .rxRdEn(rxRdEn), .rxRdData(rxRdData), .txEmpty(txEmpty), .rxFull(rxFull),
  .rxIrq(rxIrq), .rxOverrun(rxOverrun), .busBusy(busBusy),
  .busDrvReq(busDrvReq), .shLoad(shLoad), .stopReq(stopReq)
);

// File: tb/i2c_byte_buffer_tb.sv
`timescale 1ns/1ps
module i2c_byte_buffer_tb;
  localparam int DW = 8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 0, masterMode = 0, xmitDir = 0, txWrEn = 0, rxRdEn = 0, rxFlagClr = 0;
  logic byteDone = 0, byteIsAddr = 0, ackBit = 0, addrMatch = 0, arbLost = 0;
  logic startDet = 0, stopDet = 0;
  logic [DW-1:0] txWrData = '0, byteRx = '0;
  logic [DW-1:0] rxRdData, shData;
  logic txEmpty, rxFull, rxIrq, rxOverrun, busBusy, busDrvReq, shLoad, stopReq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  i2c_byte_buffer #(.DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .masterMode(masterMode),
    .xmitDir(xmitDir), .txWrEn(txWrEn), .txWrData(txWrData), .rxRdEn(rxRdEn),
    .rxFlagClr(rxFlagClr), .byteDone(byteDone), .byteIsAddr(byteIsAddr),
    .byteRx(byteRx), .ackBit(ackBit), .addrMatch(addrMatch), .arbLost(arbLost),
    .startDet(startDet), .stopDet(stopDet), .rxRdData(rxRdData),
    .txEmpty(txEmpty), .rxFull(rxFull), .rxIrq(rxIrq), .rxOverrun(rxOverrun),
    .busBusy(busBusy), .busDrvReq(busDrvReq), .shLoad(shLoad), .shData(shData),
    .stopReq(stopReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one-cycle strobes, driven on the falling edge; result visible after
  task automatic wrTx(input logic [DW-1:0] d);
    @(negedge clk); txWrEn = 1; txWrData = d;
    @(negedge clk); txWrEn = 0;
  endtask
  task automatic rdRx();
    @(negedge clk); rxRdEn = 1;
    @(negedge clk); rxRdEn = 0;
  endtask
  task automatic flagClr();
    @(negedge clk); rxFlagClr = 1;
    @(negedge clk); rxFlagClr = 0;
  endtask
  task automatic engByte(input logic isA, input logic ack, input logic match, input logic [DW-1:0] d);
    @(negedge clk); byteDone = 1; byteIsAddr = isA; ackBit = ack; addrMatch = match; byteRx = d;
    @(negedge clk); byteDone = 0; byteIsAddr = 0; ackBit = 0; addrMatch = 0;
  endtask
  task automatic pulseStart();
    @(negedge clk); startDet = 1;
    @(negedge clk); startDet = 0;
  endtask
  task automatic pulseStop();
    @(negedge clk); stopDet = 1;
    @(negedge clk); stopDet = 0;
  endtask

  task automatic tResetState();
    chk("R11 disabled txEmpty", txEmpty, 0);
    chk("R11 disabled busBusy", busBusy, 0);
    chk("R11 disabled rxRdData", rxRdData, 0);
    wrTx(8'hEE);
    @(negedge clk); enable = 1; #1;
    chk("R11 enabled txEmpty", txEmpty, 1);
    chk("R11 write while off ignored", rxFull | rxIrq | shLoad, 0);
  endtask

  task automatic tMasterTx();
    masterMode = 1; xmitDir = 1;
    pulseStart();
    chk("R10 busy after start", busBusy, 1);
    chk("R9 drive after start", busDrvReq, 1);
    engByte(1, 0, 0, 8'h00);
    chk("R1 ack with nothing pending", shLoad, 0);
    wrTx(8'hA5);
    chk("R1 pending txEmpty", txEmpty, 0);
    engByte(1, 0, 0, 8'h00);
    chk("R1 addr ack shLoad", shLoad, 1);
    chk("R1 addr ack shData", shData, 8'hA5);
    chk("R1 txEmpty after load", txEmpty, 1);
    @(negedge clk);
    chk("R1 shLoad single pulse", shLoad, 0);
    wrTx(8'h3C);
    engByte(0, 0, 0, 8'h00);
    chk("R1 data ack shData", shData, 8'h3C);
    chk("R1 data ack shLoad", shLoad, 1);
  endtask

  task automatic tMasterNack();
    wrTx(8'h77);
    engByte(0, 1, 0, 8'h00);
    chk("R2 no load on nack", shLoad, 0);
    chk("R2 txEmpty held", txEmpty, 0);
    chk("R2 stopReq", stopReq, 1);
    chk("R2 shData unchanged", shData, 8'h3C);
    @(negedge clk);
    chk("R2 stopReq single", stopReq, 0);
    pulseStop();
    chk("R10 busy cleared by stop", busBusy, 0);
    chk("R9 drive off after stop", busDrvReq, 0);
    @(negedge clk); enable = 0;
    @(negedge clk); enable = 1;
  endtask

  task automatic tSlaveTx();
    masterMode = 0; xmitDir = 1;
    wrTx(8'h5A);
    engByte(1, 0, 0, 8'h90);
    chk("R3 unmatched no load", shLoad, 0);
    chk("R3 still waiting", txEmpty, 0);
    chk("R4 unmatched addr ignored", rxFull, 0);
    engByte(1, 1, 1, 8'h91);
    chk("R3 call loads", shLoad, 1);
    chk("R3 call shData", shData, 8'h5A);
    chk("R4 calling address shown", rxRdData, 8'h91);
    rdRx();
    chk("R6 read clears full", rxFull, 0);
    flagClr();
    chk("R7 clear irq", rxIrq, 0);
  endtask

  task automatic tSlaveRx();
    xmitDir = 0;
    engByte(1, 0, 1, 8'h42);
    chk("R4 slave addr captured", rxRdData, 8'h42);
    chk("R7 irq on load", rxIrq, 1);
    rdRx();
    engByte(0, 0, 0, 8'h99);
    chk("R4 slave data captured", rxRdData, 8'h99);
    chk("R4 rxFull", rxFull, 1);
    rdRx();
    flagClr();
  endtask

  task automatic tMasterRx();
    masterMode = 1; xmitDir = 0;
    engByte(1, 0, 1, 8'hE1);
    chk("R5 master addr not captured", rxFull, 0);
    chk("R5 master addr rxRdData", rxRdData, 8'h99);
    engByte(0, 0, 0, 8'h11);
    chk("R5 master data captured", rxRdData, 8'h11);
  endtask

  task automatic tOverrun();
    flagClr();
    engByte(0, 0, 0, 8'h22);
    chk("R6 held byte not visible", rxRdData, 8'h11);
    chk("R7 hold sets no irq", rxIrq, 0);
    chk("R8 no overrun yet", rxOverrun, 0);
    engByte(0, 0, 0, 8'h33);
    chk("R8 overrun set", rxOverrun, 1);
    chk("R8 visible kept", rxRdData, 8'h11);
    rdRx();
    chk("R6 hold moves up", rxRdData, 8'h22);
    chk("R6 still full", rxFull, 1);
    chk("R7 irq on hold move", rxIrq, 1);
    rdRx();
    chk("R8 third byte discarded", rxFull, 0);
    flagClr();
    chk("R8 overrun cleared", rxOverrun, 0);
    @(negedge clk); rxFlagClr = 1; byteDone = 1; byteRx = 8'h44;
    @(negedge clk); rxFlagClr = 0; byteDone = 0;
    chk("R7 load wins over clear", rxIrq, 1);
    chk("R7 load value", rxRdData, 8'h44);
  endtask

  task automatic tArbRecovery();
    xmitDir = 1;
    pulseStart();
    chk("R9 drive before loss", busDrvReq, 1);
    @(negedge clk); arbLost = 1; #1;
    chk("R9 release same cycle", busDrvReq, 0);
    @(negedge clk); arbLost = 0; #1;
    chk("R9 stays released", busDrvReq, 0);
    chk("R10 busy without stop", busBusy, 1);
    @(negedge clk); enable = 0;
    @(negedge clk);
    chk("R10 disable clears busy", busBusy, 0);
    chk("R11 disable clears rx", rxRdData, 0);
    enable = 1; #1;
    chk("R10 resumed txEmpty", txEmpty, 1);
    pulseStart();
    chk("R10 busy again", busBusy, 1);
    pulseStop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tResetState();
    tMasterTx();
    tMasterNack();
    tSlaveTx();
    tSlaveRx();
    tMasterRx();
    tOverrun();
    tArbRecovery();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule